// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 / Clause 45)

This block is a register-programmed controller that drives a two-wire management bus (MDC clock, bidirectional MDIO data) to read and write PHY registers. Software loads a target address register, optionally picks one of the low ports as a Clause 22 target through a one-hot port register, and then writes a command word. The busy flag in that command word starts the transaction. The controller derives MDC from the system clock, shifts out the frames, releases the data line for reads, and clears busy when the last frame ends. Read data is then available in the low half of the command word.

The port address and the one-hot port register together choose the frame style. If the addressed port is one of the low Clause 22 ports and its port-register bit is set, a single direct Clause 22 frame is sent. Otherwise an indirect Clause 45 pair is sent: an address frame followed by an operation frame. Software can ask for the address frame to be skipped. A post-increment read advances the held Clause 45 register address once the read finishes.

The sequencer has four states. SQ_IDLE moves to SQ_BIT_LOW on a launch. SQ_BIT_LOW moves to SQ_BIT_HIGH on a half-period tick, which is when MDC rises and the input is sampled. SQ_BIT_HIGH moves back to SQ_BIT_LOW on a tick when more bits remain, or when the address frame ends and the operation frame is chained in. When the last bit of the operation frame ends on a tick, SQ_BIT_HIGH moves to SQ_DONE. SQ_DONE returns to SQ_IDLE after one cycle, and busy clears in that transition.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all three registers read as zero, `mdc` is low and `mdio_oe` is low.
- R2: Register selects are 0 for the address register, 1 for the command word and 2 for the port register. The command word layout is data in bits 15:0, command in bits 17:16 (1 write, 2 read with post-increment, 3 read), skip flag in bit 18, clock range in bits 21:19 and busy in bit 22. Writing it with bit 22 set and a non-zero command starts a transaction. With command 0 the fields are stored, busy reads 0 and no MDC edge occurs.
- R3: The MDC period is 4·2^range system clocks, half low and half high, so the ranges give divide ratios 4 to 512.
- R4: A Clause 22 frame is used when the address register port field (bits 20:16) is below 4 and the matching bit of the port register (bit n for port n) is set. It is one 64-bit frame, sent MSB first: 32 ones, start 01, opcode 01 for a write or 10 for a read (commands 2 and 3), port, register number from address bits 4:0, turnaround, 16 data bits.
- R5: Otherwise a Clause 45 address frame is sent first: 32 ones, 00, 00, port, device (address bits 25:21), turnaround 10, register address (bits 15:0). It is followed by an operation frame with start 00, opcode 01 for a write, 11 for a read or 10 for a post-increment read, then port, device, turnaround and data.
- R6: With the skip flag set, a Clause 45 transaction sends only the operation frame.
- R7: In read frames `mdio_oe` is low for the last 18 bit slots (turnaround and data). The 16 data bits are sampled on rising MDC, MSB first, and appear in command-word bits 15:0 once busy clears.
- R8: In write frames every slot is driven, the turnaround is 10, and the data bits come from command-word bits 15:0, which stay unchanged afterwards.
- R9: A Clause 45 post-increment read adds one (modulo 2^16) to address bits 15:0 after it completes. A Clause 22 transaction never changes the address register.
- R10: While busy is set, writes to any of the three registers are ignored.
- R11: Busy clears only when the sequence finishes. After that, `mdc` and `mdio_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 address, 1 command, 2 port) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench targets several corner cases. A port-register bit set for a port at or above 4 must still produce a Clause 45 pair; a decoder that indexed the port register without the range check would emit a Clause 22 frame instead. A post-increment read at register address FFFF must wrap to 0000, and the same command on a Clause 22 target must leave the address alone. Writes poked into every register while busy must leave both the frames and the readback unchanged, and a design that honoured them would corrupt the frames on the wire. The largest clock range and the turnaround release are measured directly, and a command of 0 must not start MDC.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_SLOT    = 46;
    localparam int DATA_SLOT  = 48;
    localparam logic [31:0] PREAMBLE = 32'hFFFF_FFFF;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_PORT = 2'd2;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_WRITE  = 2'd1,
        CMD_RD_INC = 2'd2,
        CMD_READ   = 2'd3
    } mdio_cmd_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_BIT_LOW,
        SQ_BIT_HIGH,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic [4:0]  dev;
        logic [4:0]  prt;
        logic [15:0] regad;
    } addr_fields_t;

    typedef struct packed {
        logic        busy;
        logic [2:0]  clk_range;
        logic        skip_addr;
        mdio_cmd_e   cmd;
        logic [15:0] data;
    } cmd_fields_t;

    function automatic logic [FRAME_BITS-1:0] frame_c22(
        input mdio_cmd_e   c,
        input logic [4:0]  prt,
        input logic [4:0]  rnum,
        input logic [15:0] d
    );
        logic rd;
        rd = (c != CMD_WRITE);
        return {PREAMBLE, 2'b01, (rd ? 2'b10 : 2'b01), prt, rnum,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_c45_addr(
        input logic [4:0]  prt,
        input logic [4:0]  dev,
        input logic [15:0] regad
    );
        return {PREAMBLE, 2'b00, 2'b00, prt, dev, 2'b10, regad};
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_c45_op(
        input mdio_cmd_e   c,
        input logic [4:0]  prt,
        input logic [4:0]  dev,
        input logic [15:0] d
    );
        logic [1:0] op;
        logic       rd;
        rd = (c != CMD_WRITE);
        unique case (c)
            CMD_WRITE:  op = 2'b01;
            CMD_READ:   op = 2'b11;
            CMD_RD_INC: op = 2'b10;
            default:    op = 2'b00;
        endcase
        return {PREAMBLE, 2'b00, op, prt, dev,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
    endfunction

endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int C22_PORTS = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              done,
    input  logic              rd_valid,
    input  logic [15:0]       rd_data,
    output addr_fields_t      addr_o,
    output cmd_fields_t       cmdf_o,
    output logic              is_c22,
    output logic              launch
);

    localparam int ADDR_W = $bits(addr_fields_t);
    localparam int CMD_W  = $bits(cmd_fields_t);

    addr_fields_t         addr_q;
    cmd_fields_t          cmdf_q;
    logic [C22_PORTS-1:0] port_q;
    logic                 wr_ok;
    logic                 inc_en;
    logic                 go;

    assign wr_ok  = reg_wr && !cmdf_q.busy;
    assign go     = reg_wdata[22] && (reg_wdata[17:16] != 2'b00);
    assign inc_en = (cmdf_q.cmd == CMD_RD_INC) && !is_c22;

    always_comb begin
        is_c22 = 1'b0;
        for (int i = 0; i < C22_PORTS; i++) begin
            if ((addr_q.prt == 5'(i)) && port_q[i]) begin
                is_c22 = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmdf_q <= '0;
            port_q <= '0;
            launch <= 1'b0;
        end else begin
            launch <= 1'b0;
            if (done) begin
                cmdf_q.busy <= 1'b0;
                if (rd_valid) begin
                    cmdf_q.data <= rd_data;
                end
                if (inc_en) begin
                    addr_q.regad <= addr_q.regad + 16'd1;
                end
            end else if (wr_ok) begin
                unique case (reg_sel)
                    SEL_ADDR: addr_q <= addr_fields_t'(reg_wdata[ADDR_W-1:0]);
                    SEL_CMD: begin
                        cmdf_q.data      <= reg_wdata[15:0];
                        cmdf_q.cmd       <= mdio_cmd_e'(reg_wdata[17:16]);
                        cmdf_q.skip_addr <= reg_wdata[18];
                        cmdf_q.clk_range <= reg_wdata[21:19];
                        cmdf_q.busy      <= go;
                        launch           <= go;
                    end
                    SEL_PORT: port_q <= reg_wdata[C22_PORTS-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_ADDR: reg_rdata = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
            SEL_CMD:  reg_rdata = {{(DATA_W-CMD_W){1'b0}}, cmdf_q};
            SEL_PORT: reg_rdata = {{(DATA_W-C22_PORTS){1'b0}}, port_q};
            default:  reg_rdata = '0;
        endcase
    end

    assign addr_o = addr_q;
    assign cmdf_o = cmdf_q;

    AST_BUSY_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmdf_q.busy && !done) |=> ($stable(addr_q) && $stable(port_q) && $stable(cmdf_q))); // R10

    AST_BUSY_FALLS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmdf_q.busy) |-> $past(done)); // R11

endmodule

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
    parameter int BASE_HALF = 2,
    parameter int RANGE_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [RANGE_W-1:0] range_sel,
    output logic               tick
);

    localparam int MAX_HALF = BASE_HALF << ((1 << RANGE_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = (CNT_W'(BASE_HALF) << range_sel) - CNT_W'(1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_TIMER_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit)); // R3

endmodule

// File: rtl/mdio_seq_fsm.sv
module mdio_seq_fsm
    import mdio_mgmt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch,
    input  logic         is_c22,
    input  logic         skip_addr,
    input  mdio_cmd_e    cmd,
    input  addr_fields_t addr,
    input  logic [15:0]  wdata,
    input  logic         tick,
    input  logic         mdio_i,
    output logic         run,
    output logic         mdc,
    output logic         mdio_o,
    output logic         mdio_oe,
    output logic         done,
    output logic         rd_valid,
    output logic [15:0]  rd_data
);

    localparam int BIT_W = $clog2(FRAME_BITS);

    seq_state_e            state_q, state_d;
    logic [FRAME_BITS-1:0] frm_q;
    logic [BIT_W-1:0]      bit_q;
    logic [BIT_W-1:0]      bit_nx;
    logic                  op_phase_q;
    logic                  rd_frame_q;
    logic [15:0]           rd_sh_q;

    logic [FRAME_BITS-1:0] addr_frame;
    logic [FRAME_BITS-1:0] op_frame;
    logic [FRAME_BITS-1:0] first_frame;
    logic                  first_is_addr;
    logic                  op_is_rd;
    logic                  last_bit;

    assign addr_frame    = frame_c45_addr(addr.prt, addr.dev, addr.regad);
    assign op_frame      = is_c22 ? frame_c22(cmd, addr.prt, addr.regad[4:0], wdata)
                                  : frame_c45_op(cmd, addr.prt, addr.dev, wdata);
    assign first_is_addr = !is_c22 && !skip_addr;
    assign first_frame   = first_is_addr ? addr_frame : op_frame;
    assign op_is_rd      = (cmd != CMD_WRITE);
    assign last_bit      = (bit_q == BIT_W'(FRAME_BITS - 1));
    assign bit_nx        = bit_q + BIT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:     if (launch) state_d = SQ_BIT_LOW;
            SQ_BIT_LOW:  if (tick)   state_d = SQ_BIT_HIGH;
            SQ_BIT_HIGH: if (tick)   state_d = (last_bit && op_phase_q) ? SQ_DONE : SQ_BIT_LOW;
            SQ_DONE:                 state_d = SQ_IDLE;
            default:                 state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q      <= '0;
            bit_q      <= '0;
            op_phase_q <= 1'b0;
            rd_frame_q <= 1'b0;
            rd_sh_q    <= '0;
            mdc        <= 1'b0;
            mdio_o     <= 1'b0;
            mdio_oe    <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (launch) begin
                        frm_q      <= first_frame;
                        bit_q      <= '0;
                        op_phase_q <= !first_is_addr;
                        rd_frame_q <= !first_is_addr && op_is_rd;
                        mdio_o     <= first_frame[FRAME_BITS-1];
                        mdio_oe    <= 1'b1;
                    end
                end
                SQ_BIT_LOW: begin
                    if (tick) begin
                        mdc <= 1'b1;
                        if (rd_frame_q && (bit_q >= BIT_W'(DATA_SLOT))) begin
                            rd_sh_q <= {rd_sh_q[14:0], mdio_i};
                        end
                    end
                end
                SQ_BIT_HIGH: begin
                    if (tick) begin
                        mdc <= 1'b0;
                        if (last_bit && !op_phase_q) begin
                            frm_q      <= op_frame;
                            bit_q      <= '0;
                            op_phase_q <= 1'b1;
                            rd_frame_q <= op_is_rd;
                            mdio_o     <= op_frame[FRAME_BITS-1];
                            mdio_oe    <= 1'b1;
                        end else if (last_bit) begin
                            mdio_o  <= 1'b0;
                            mdio_oe <= 1'b0;
                        end else begin
                            bit_q   <= bit_nx;
                            frm_q   <= {frm_q[FRAME_BITS-2:0], 1'b0};
                            mdio_o  <= frm_q[FRAME_BITS-2];
                            mdio_oe <= !(rd_frame_q && (bit_nx >= BIT_W'(TA_SLOT)));
                        end
                    end
                end
                SQ_DONE: begin
                    mdc     <= 1'b0;
                    mdio_oe <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign run      = (state_q == SQ_BIT_LOW) || (state_q == SQ_BIT_HIGH);
    assign done     = (state_q == SQ_DONE);
    assign rd_valid = rd_frame_q;
    assign rd_data  = rd_sh_q;

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE) |-> (!mdc && !mdio_oe)); // R11

    AST_LAUNCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (state_q == SQ_IDLE)); // R10

    AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (bit_q < BIT_W'(32))) |-> (mdio_oe && mdio_o)); // R4

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rd_frame_q && (bit_q >= BIT_W'(TA_SLOT))) |-> !mdio_oe); // R7

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int C22_PORTS = 4,
    parameter int BASE_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    addr_fields_t addr;
    cmd_fields_t  cmdf;
    logic         is_c22;
    logic         launch;
    logic         done;
    logic         rd_valid;
    logic [15:0]  rd_data;
    logic         run;
    logic         tick;

    mdio_mgmt_regs #(
        .C22_PORTS (C22_PORTS),
        .DATA_W    (32)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .done      (done),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .addr_o    (addr),
        .cmdf_o    (cmdf),
        .is_c22    (is_c22),
        .launch    (launch)
    );

    mdio_mdc_timer #(
        .BASE_HALF (BASE_HALF),
        .RANGE_W   (3)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .range_sel (cmdf.clk_range),
        .tick      (tick)
    );

    mdio_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .is_c22    (is_c22),
        .skip_addr (cmdf.skip_addr),
        .cmd       (cmdf.cmd),
        .addr      (addr),
        .wdata     (cmdf.data),
        .tick      (tick),
        .mdio_i    (mdio_i),
        .run       (run),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    int cyc = 0;
    int pos = 0;
    int ncap = 0;
    int last_rise = 0;
    int per_err = 0;
    int exp_period = 4;
    logic [63:0] cur_v = '0, cur_oe = '0;
    logic [63:0] cap_v [4];
    logic [63:0] cap_oe [4];
    logic [15:0] phy_val = 16'h0;

    int          exp_n;
    logic [63:0] exp_v [2];
    logic [63:0] exp_oe [2];

    mdio_mgmt_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cyc++;

    // PHY-side responder: captures master bits on rising MDC, drives read data after falling MDC
    always @(posedge mdc) begin
        cur_v  = {cur_v[62:0], mdio_o};
        cur_oe = {cur_oe[62:0], mdio_oe};
        if (pos > 0 && (cyc - last_rise) != exp_period) per_err++;
        last_rise = cyc;
        pos++;
        if (pos == 64) begin
            if (ncap < 4) begin
                cap_v[ncap]  = cur_v;
                cap_oe[ncap] = cur_oe;
            end
            ncap++;
            pos = 0;
        end
    end

    always @(negedge mdc) begin
        if (pos >= 48) mdio_i = phy_val[63 - pos];
        else           mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do rd(2'd1, v); while (v[22]);
        repeat (4) @(negedge clk);
    endtask

    // Expected frames from R4/R5/R6/R7/R8
    task automatic build_exp(input logic [25:0] a, input logic [3:0] ps, input logic [1:0] c,
                             input logic sk, input logic [15:0] wd, output bit c22);
        logic [4:0] prt, dev;
        logic [15:0] rg;
        logic rdop;
        logic [1:0] op;
        logic [63:0] oe_rd;
        prt = a[20:16]; dev = a[25:21]; rg = a[15:0];
        c22 = (prt < 5'd4) && ps[prt[1:0]];
        rdop = (c != 2'd1);
        oe_rd = {{46{1'b1}}, 18'h0};
        if (c22) begin
            exp_n = 1;
            exp_v[0] = {32'hFFFFFFFF, 2'b01, rdop ? 2'b10 : 2'b01, prt, rg[4:0],
                        rdop ? 2'b00 : 2'b10, rdop ? 16'h0 : wd};
            exp_oe[0] = rdop ? oe_rd : '1;
        end else begin
            op = (c == 2'd1) ? 2'b01 : (c == 2'd3) ? 2'b11 : 2'b10;
            exp_v[1] = {32'hFFFFFFFF, 2'b00, op, prt, dev, rdop ? 2'b00 : 2'b10, rdop ? 16'h0 : wd};
            exp_oe[1] = rdop ? oe_rd : '1;
            if (sk) begin
                exp_n = 1;
                exp_v[0] = exp_v[1]; exp_oe[0] = exp_oe[1];
            end else begin
                exp_n = 2;
                exp_v[0] = {32'hFFFFFFFF, 2'b00, 2'b00, prt, dev, 2'b10, rg};
                exp_oe[0] = '1;
            end
        end
    endtask

    task automatic do_txn(input logic [25:0] a, input logic [3:0] ps, input logic [1:0] c,
                          input logic sk, input logic [2:0] rng, input logic [15:0] wd, input bit poke);
        bit c22;
        logic [31:0] v;
        logic [15:0] exp_rg;
        string ftag;
        build_exp(a, ps, c, sk, wd, c22);
        exp_period = 4 << rng;
        wr(2'd0, {6'b0, a});
        wr(2'd2, {28'b0, ps});
        ncap = 0; per_err = 0;
        wr(2'd1, {9'b0, 1'b1, rng, sk, c, wd});
        if (poke) begin
            wr(2'd0, ~{6'b0, a});
            wr(2'd2, {28'b0, ~ps});
            wr(2'd1, {9'b0, 1'b1, ~rng, ~sk, 2'd1, ~wd});
        end
        wait_idle();
        ftag = c22 ? "R4" : (sk ? "R6" : "R5");
        chk(ncap == exp_n, {ftag, " frame count"}, 64'(ncap), 64'(exp_n));
        for (int i = 0; i < 2; i++) begin
            if (i < exp_n && i < ncap) begin
                chk((cap_v[i] & exp_oe[i]) == (exp_v[i] & exp_oe[i]), {ftag, " frame bits"}, cap_v[i], exp_v[i]);
                chk(cap_oe[i] == exp_oe[i], (c != 2'd1) ? "R7 read release" : "R8 write drive", cap_oe[i], exp_oe[i]);
            end
        end
        chk(per_err == 0, "R3 mdc period", 64'(per_err), 64'(0));
        rd(2'd1, v);
        chk(v[22] == 1'b0, "R11 busy cleared", 64'(v[22]), 64'(0));
        if (c != 2'd1) chk(v[15:0] == phy_val, "R7 read data", 64'(v[15:0]), 64'(phy_val));
        else           chk(v[15:0] == wd, "R8 data kept", 64'(v[15:0]), 64'(wd));
        rd(2'd0, v);
        exp_rg = (!c22 && c == 2'd2) ? a[15:0] + 16'd1 : a[15:0];
        chk(v[25:0] == {a[25:16], exp_rg}, poke ? "R10 addr untouched" : "R9 addr update",
            64'(v[25:0]), 64'({a[25:16], exp_rg}));
        rd(2'd2, v);
        chk(v[3:0] == ps, "R10 port reg", 64'(v[3:0]), 64'(ps));
        chk(!mdc && !mdio_oe, "R11 bus idle", 64'({mdc, mdio_oe}), 64'(0));
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); chk(v == 0, "R1 addr reset", 64'(v), 0);
        rd(2'd1, v); chk(v == 0, "R1 cmd reset", 64'(v), 0);
        rd(2'd2, v); chk(v == 0, "R1 port reset", 64'(v), 0);
        chk(!mdc && !mdio_oe, "R1 bus reset", 64'({mdc, mdio_oe}), 0);

        // R2 command 0 with busy does not launch
        ncap = 0;
        wr(2'd1, {9'b0, 1'b1, 3'd5, 1'b1, 2'd0, 16'hABCD});
        rd(2'd1, v);
        chk(v == {9'b0, 1'b0, 3'd5, 1'b1, 2'd0, 16'hABCD}, "R2 no launch fields", 64'(v),
            64'({9'b0, 1'b0, 3'd5, 1'b1, 2'd0, 16'hABCD}));
        repeat (60) @(negedge clk);
        chk(ncap == 0 && pos == 0 && !mdc, "R2 no mdc activity", 64'(pos), 0);

        // Directed corner cases
        phy_val = 16'h5A3C;
        do_txn({5'd7, 5'd2, 16'h0013}, 4'b0100, 2'd1, 1'b0, 3'd7, 16'hBEEF, 0); // R4 C22 write, R3 slowest range
        do_txn({5'd3, 5'd1, 16'hFFFF}, 4'b0000, 2'd2, 1'b0, 3'd0, 16'h0, 0);    // R9 wrap
        do_txn({5'd3, 5'd1, 16'h0021}, 4'b0010, 2'd2, 1'b0, 3'd1, 16'h0, 0);    // R9 C22 no increment
        do_txn({5'd9, 5'd6, 16'h1234}, 4'b1111, 2'd3, 1'b1, 3'd0, 16'h0, 0);    // R6 skip, port >= 4
        do_txn({5'd4, 5'd5, 16'h00FF}, 4'b0001, 2'd1, 1'b0, 3'd1, 16'hC0DE, 1); // R10 pokes while busy

        // Constrained random mix
        for (int n = 0; n < 28; n++) begin
            logic [25:0] a;
            a = $urandom;
            a[20:16] = 5'($urandom % 6);
            phy_val = 16'($urandom);
            do_txn(a, 4'($urandom), 2'(1 + $urandom % 3), 1'($urandom), 3'($urandom % 3),
                   16'($urandom), 1'($urandom % 4 == 0));
        end

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule